// File: doc/BRIEF.md
# Thermal Trip Throttling Controller

This block guards a processor core against overheating. It takes two trip levels from on-die temperature sensors. The higher one is a last-resort trip. Once it fires, the core is stopped and stays stopped until reset; software cannot turn this path off. The lower one is the monitor trip. It starts a throttle episode, and software decides how that episode is handled.

Two throttle methods share the monitor trip. The first reduces the duty cycle of the core clock enable inside a repeating window of eight cycles. The second asks an external power manager for a lower frequency and voltage point. It does this through a request/acknowledge exchange, and it asks for the normal point again once the episode is over. When both methods are enabled, the second one wins. The clock-stopping used for throttling is made inside the block and needs no external stop-clock signal.

A small register port gives software the method selections and the duty value. It also gives a status word: the synchronized trip levels, a sticky record that throttling happened, and the halt state.

Top module: `thermal_guard`

## Requirements
- R1: A catastrophic trip raised before clock edge k is synchronized through two flops and sets `core_halt_o` after edge k+2, whatever the control register holds.
- R2: Once set, `core_halt_o` stays high until a reset, even after the trip input falls, and `core_clk_en_o` is low for as long as it is high.
- R3: After reset the control register reads zero, `core_clk_en_o` is high, `core_halt_o` is low, and no operating-point request is pending.
- R4: While an episode is active with control bit 3 set and bit 16 clear, `core_clk_en_o` is high for N cycles of every 8, where N is control bits [10:8]; N = 0 behaves as 4.
- R5: An episode starts one cycle after the synchronized monitor level is seen high. It ends only after that level has been low for 16 consecutive cycles, and any high cycle restarts the count.
- R6: With control bit 16 set, an episode raises `opp_req_o` with `opp_low_o` = 1, held until `opp_ack_i` is sampled high. After the episode ends, the block raises `opp_req_o` with `opp_low_o` = 0, held the same way. `opp_low_o` stays 1 from the lowering request until the release request begins.
- R7: When control bits 3 and 16 are both set, clock gating is suppressed and only the operating-point request acts.
- R8: Reads at address 0 return the control register: bit 3 gating enable, bits [10:8] duty, bit 16 operating-point select. Reads at address 1 return status: bit 0 synchronized catastrophic level, bit 1 synchronized monitor level, bit 2 throttle-occurred flag, bit 3 halt.
- R9: The throttle-occurred flag is set in every cycle in which an episode is active with either method enabled. Writing 1 to status bit 2 clears it; writing 0 leaves it set; a set in the same cycle wins.
- R10: An episode with neither method enabled leaves `core_clk_en_o` high, raises no request, and does not set the throttle-occurred flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cat_trip_i | input | 1 | Catastrophic trip level, asynchronous |
| mon_trip_i | input | 1 | Monitor trip level, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 control, 1 status |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for the selected register |
| core_halt_o | output | 1 | Core halt, sticky until reset |
| core_clk_en_o | output | 1 | Core clock enable |
| opp_req_o | output | 1 | Operating-point change request |
| opp_low_o | output | 1 | Requested direction: 1 lower point, 0 normal point |
| opp_ack_i | input | 1 | Operating-point change acknowledge |

## Verification
The hardest overlap is the end of an episode landing while the lowering request is still waiting for its acknowledge. To provoke it, the bench sends a short monitor pulse and delays the acknowledge well past the 16-cycle quiet window. The block must then finish the lowering exchange and only after that issue the release. A second overlap is a catastrophic trip arriving in the middle of clock gating, where the halt must override the duty pattern in the same cycle. Both overlaps are judged cycle by cycle against a behavioural reference model running alongside the design.

// File: rtl/thermal_guard_pkg.sv
// Shared constants and types for the thermal trip throttling controller.
// Assumes a 1-bit register address and a data width of at least 17 bits.
package thermal_guard_pkg;

    // Register selects
    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_STAT = 1'b1;

    // Control register field positions
    localparam int CTRL_GATE_BIT = 3;
    localparam int CTRL_DUTY_LSB = 8;
    localparam int CTRL_OPP_BIT  = 16;

    // Status register field positions
    localparam int STAT_CAT_BIT    = 0;
    localparam int STAT_MON_BIT    = 1;
    localparam int STAT_STICKY_BIT = 2;
    localparam int STAT_HALT_BIT   = 3;

    // Operating-point request sequencer states
    typedef enum logic [1:0] {
        OPP_NORMAL  = 2'd0,
        OPP_ASK_LOW = 2'd1,
        OPP_LOWERED = 2'd2,
        OPP_ASK_REL = 2'd3
    } opp_state_e;

endpackage

// File: rtl/tg_sync.sv
// Multi-flop level synchronizer for one asynchronous trip input.
// Assumes STAGES >= 1; the output is low during and right after reset.
module tg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            // Single-stage capture of the raw level
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d_i;
            end
        end else begin : g_multi
            // Shift the raw level through the flop chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/tg_episode.sv
// Tracks a throttle episode from the synchronized monitor level.
// An episode opens on any high cycle and closes after QUIET_CYCLES
// consecutive low cycles. Assumes QUIET_CYCLES >= 2.
module tg_episode #(
    parameter int QUIET_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_i,
    output logic active_o
);

    localparam int CW = $clog2(QUIET_CYCLES);
    localparam logic [CW-1:0] QUIET_LAST = CW'(QUIET_CYCLES - 1);

    logic          active_q;
    logic [CW-1:0] quiet_q;

    // Open on a trip, count quiet cycles, close when the count completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            quiet_q  <= '0;
        end else if (trip_i) begin
            active_q <= 1'b1;
            quiet_q  <= '0;
        end else if (active_q) begin
            if (quiet_q == QUIET_LAST) begin
                active_q <= 1'b0;
                quiet_q  <= '0;
            end else begin
                quiet_q  <= quiet_q + 1'b1;
            end
        end
    end

    assign active_o = active_q;

endmodule

// File: rtl/tg_duty_gate.sv
// Clock-enable duty modulator over a window of 2**WIN_W cycles.
// The enable is high in the first N phases of each window; N = 0 acts
// as half the window. The phase counter runs freely from reset.
module tg_duty_gate #(
    parameter int WIN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_on_i,
    input  logic [WIN_W-1:0] duty_i,
    output logic             allow_o
);

    localparam logic [WIN_W:0] HALF_WIN = (WIN_W+1)'(1) << (WIN_W - 1);

    logic [WIN_W-1:0] phase_q;
    logic [WIN_W:0]   duty_eff;

    // Free-running window phase
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_q + 1'b1;
    end

    // Map a zero duty field onto the half-window default
    always_comb begin
        if (duty_i == '0) duty_eff = HALF_WIN;
        else              duty_eff = {1'b0, duty_i};
    end

    // Pass the enable unless gating is on and the phase is past the duty
    assign allow_o = !gate_on_i || ({1'b0, phase_q} < duty_eff);

endmodule

// File: rtl/tg_opp_fsm.sv
// Operating-point request sequencer. Raises a lowering request while
// throttling is wanted and a release request once it is not; each
// request holds until the acknowledge is sampled. Assumes the
// acknowledge is synchronous to clk.
module tg_opp_fsm
    import thermal_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic want_low_i,
    input  logic ack_i,
    output logic req_o,
    output logic low_o
);

    opp_state_e state_q, state_d;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OPP_NORMAL:  if (want_low_i) state_d = OPP_ASK_LOW;
            OPP_ASK_LOW: if (ack_i)      state_d = OPP_LOWERED;
            OPP_LOWERED: if (!want_low_i) state_d = OPP_ASK_REL;
            OPP_ASK_REL: if (ack_i)      state_d = OPP_NORMAL;
            default:                     state_d = OPP_NORMAL;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OPP_NORMAL;
        else        state_q <= state_d;
    end

    assign req_o = (state_q == OPP_ASK_LOW) || (state_q == OPP_ASK_REL);
    assign low_o = (state_q == OPP_ASK_LOW) || (state_q == OPP_LOWERED);

endmodule

// File: rtl/tg_regs.sv
// Software-visible control and status registers. Control holds the
// gating enable, duty and operating-point select; status reports the
// trip levels, halt and a sticky throttle flag cleared by writing 1.
module tg_regs
    import thermal_guard_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int WIN_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              cat_lvl_i,
    input  logic              mon_lvl_i,
    input  logic              halt_i,
    input  logic              throttling_i,
    output logic              gate_en_o,
    output logic              opp_sel_o,
    output logic [WIN_W-1:0]  duty_o,
    output logic [DATA_W-1:0] rdata_o
);

    logic             gate_en_q;
    logic             opp_sel_q;
    logic [WIN_W-1:0] duty_q;
    logic             sticky_q;
    logic             sticky_clr;
    logic             unused_wdata_bits;

    assign sticky_clr        = wr_i && (addr_i == ADDR_STAT) && wdata_i[STAT_STICKY_BIT];
    assign unused_wdata_bits = ^wdata_i;

    // Control register write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_en_q <= 1'b0;
            opp_sel_q <= 1'b0;
            duty_q    <= '0;
        end else if (wr_i && (addr_i == ADDR_CTRL)) begin
            gate_en_q <= wdata_i[CTRL_GATE_BIT];
            opp_sel_q <= wdata_i[CTRL_OPP_BIT];
            duty_q    <= wdata_i[CTRL_DUTY_LSB +: WIN_W];
        end
    end

    // Sticky throttle flag: set wins over a write-one clear
    always_ff @(posedge clk) begin
        if (!rst_n)            sticky_q <= 1'b0;
        else if (throttling_i) sticky_q <= 1'b1;
        else if (sticky_clr)   sticky_q <= 1'b0;
    end

    // Read multiplexer
    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_CTRL) begin
            rdata_o[CTRL_GATE_BIT]               = gate_en_q;
            rdata_o[CTRL_OPP_BIT]                = opp_sel_q;
            rdata_o[CTRL_DUTY_LSB +: WIN_W]      = duty_q;
        end else begin
            rdata_o[STAT_CAT_BIT]    = cat_lvl_i;
            rdata_o[STAT_MON_BIT]    = mon_lvl_i;
            rdata_o[STAT_STICKY_BIT] = sticky_q;
            rdata_o[STAT_HALT_BIT]   = halt_i;
        end
    end

    assign gate_en_o = gate_en_q;
    assign opp_sel_o = opp_sel_q;
    assign duty_o    = duty_q;

endmodule

// File: rtl/thermal_guard.sv
// Thermal trip throttling controller top. Synchronizes both trips,
// latches the catastrophic halt, tracks monitor episodes and applies
// either duty gating or an operating-point request (request wins).
// Assumes all register and acknowledge inputs are synchronous to clk.
module thermal_guard #(
    parameter int SYNC_STAGES  = 2,
    parameter int QUIET_CYCLES = 16,
    parameter int WIN_W        = 3,
    parameter int DATA_W       = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cat_trip_i,
    input  logic              mon_trip_i,
    input  logic              reg_wr_i,
    input  logic              reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              core_halt_o,
    output logic              core_clk_en_o,
    output logic              opp_req_o,
    output logic              opp_low_o,
    input  logic              opp_ack_i
);

    logic             cat_lvl;
    logic             mon_lvl;
    logic             halt_q;
    logic             epi_act;
    logic             gate_en;
    logic             opp_sel;
    logic [WIN_W-1:0] duty;
    logic             gate_on;
    logic             gate_allow;
    logic             want_low;
    logic             throttling;

    tg_sync #(.STAGES(SYNC_STAGES)) u_cat_sync (
        .clk(clk), .rst_n(rst_n), .d_i(cat_trip_i), .q_o(cat_lvl)
    );

    tg_sync #(.STAGES(SYNC_STAGES)) u_mon_sync (
        .clk(clk), .rst_n(rst_n), .d_i(mon_trip_i), .q_o(mon_lvl)
    );

    // Catastrophic halt latch, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n)       halt_q <= 1'b0;
        else if (cat_lvl) halt_q <= 1'b1;
    end

    tg_episode #(.QUIET_CYCLES(QUIET_CYCLES)) u_episode (
        .clk(clk), .rst_n(rst_n), .trip_i(mon_lvl), .active_o(epi_act)
    );

    assign gate_on    = epi_act && gate_en && !opp_sel;
    assign want_low   = epi_act && opp_sel;
    assign throttling = epi_act && (gate_en || opp_sel);

    tg_duty_gate #(.WIN_W(WIN_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .gate_on_i(gate_on),
        .duty_i(duty), .allow_o(gate_allow)
    );

    tg_opp_fsm u_opp (
        .clk(clk), .rst_n(rst_n), .want_low_i(want_low),
        .ack_i(opp_ack_i), .req_o(opp_req_o), .low_o(opp_low_o)
    );

    tg_regs #(.DATA_W(DATA_W), .WIN_W(WIN_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
        .wdata_i(reg_wdata_i), .cat_lvl_i(cat_lvl), .mon_lvl_i(mon_lvl),
        .halt_i(halt_q), .throttling_i(throttling), .gate_en_o(gate_en),
        .opp_sel_o(opp_sel), .duty_o(duty), .rdata_o(reg_rdata_o)
    );

    assign core_halt_o   = halt_q;
    assign core_clk_en_o = !halt_q && gate_allow;

endmodule

// File: rtl/thermal_guard_chk.sv
// Property checker for the thermal trip throttling controller, bound
// to every instance of the top module.
module thermal_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic cat_lvl,
    input logic epi_act,
    input logic core_halt_o,
    input logic core_clk_en_o,
    input logic opp_req_o,
    input logic opp_low_o,
    input logic opp_ack_i
);

    // R1: a synchronized catastrophic level forces halt next cycle
    p_halt_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cat_lvl |=> core_halt_o);

    // R2: halt never drops without reset
    p_halt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        core_halt_o |=> core_halt_o);

    // R5: outside an episode the enable is not gated
    p_no_gate_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !epi_act |-> (core_clk_en_o || core_halt_o));

    // R6: an unacknowledged request holds with its direction
    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (opp_req_o && !opp_ack_i) |=> (opp_req_o && $stable(opp_low_o)));

    // R6: an acknowledged request is withdrawn
    p_req_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (opp_req_o && opp_ack_i) |=> !opp_req_o);

endmodule

bind thermal_guard thermal_guard_chk chk_i (
    .clk(clk), .rst_n(rst_n), .cat_lvl(cat_lvl), .epi_act(epi_act),
    .core_halt_o(core_halt_o), .core_clk_en_o(core_clk_en_o),
    .opp_req_o(opp_req_o), .opp_low_o(opp_low_o), .opp_ack_i(opp_ack_i)
);

// File: tb/thermal_guard_tb_top.sv
`timescale 1ns/1ps
module thermal_guard_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cat_trip = 1'b0;
    logic        mon_trip = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        core_halt, core_clk_en, opp_req, opp_low;
    logic        opp_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    int ack_delay = 2;
    bit cmp_on = 0;

    always #2 clk = ~clk;

    thermal_guard dut_i (
        .clk(clk), .rst_n(rst_n), .cat_trip_i(cat_trip), .mon_trip_i(mon_trip),
        .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .core_halt_o(core_halt),
        .core_clk_en_o(core_clk_en), .opp_req_o(opp_req), .opp_low_o(opp_low),
        .opp_ack_i(opp_ack)
    );

    // ---------------- reference model ----------------
    int m_c1, m_c2, m_m1, m_m2, m_halt, m_epi, m_quiet, m_phase;
    int m_gate, m_opp, m_duty, m_sticky, m_st;

    initial begin
        {m_c1, m_c2, m_m1, m_m2, m_halt, m_epi, m_quiet, m_phase} = '0;
        {m_gate, m_opp, m_duty, m_sticky, m_st} = '0;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_c1 = 0; m_c2 = 0; m_m1 = 0; m_m2 = 0; m_halt = 0; m_epi = 0;
            m_quiet = 0; m_phase = 0; m_gate = 0; m_opp = 0; m_duty = 0;
            m_sticky = 0; m_st = 0;
        end else begin
            if (m_c2 != 0) m_halt = 1;
            if (m_epi != 0 && (m_gate != 0 || m_opp != 0)) m_sticky = 1;
            else if (reg_wr && reg_addr && reg_wdata[2]) m_sticky = 0;
            case (m_st)
                0: if (m_epi != 0 && m_opp != 0) m_st = 1;
                1: if (opp_ack) m_st = 2;
                2: if (!(m_epi != 0 && m_opp != 0)) m_st = 3;
                default: if (opp_ack) m_st = 0;
            endcase
            if (m_m2 != 0) begin
                m_epi = 1; m_quiet = 0;
            end else if (m_epi != 0) begin
                if (m_quiet == 15) begin m_epi = 0; m_quiet = 0; end
                else m_quiet++;
            end
            m_phase = (m_phase + 1) % 8;
            if (reg_wr && !reg_addr) begin
                m_gate = int'(reg_wdata[3]);
                m_opp  = int'(reg_wdata[16]);
                m_duty = int'(reg_wdata[10:8]);
            end
            m_c2 = m_c1; m_c1 = int'(cat_trip);
            m_m2 = m_m1; m_m1 = int'(mon_trip);
        end
    end

    function automatic bit exp_en();
        int eff = (m_duty == 0) ? 4 : m_duty;
        if (m_halt != 0) return 1'b0;
        if (m_epi != 0 && m_gate != 0 && m_opp == 0 && m_phase >= eff) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [31:0] exp_rd();
        logic [31:0] r = '0;
        if (!reg_addr) begin
            r[3] = (m_gate != 0); r[16] = (m_opp != 0); r[10:8] = 3'(m_duty);
        end else begin
            r[0] = (m_c2 != 0); r[1] = (m_m2 != 0);
            r[2] = (m_sticky != 0); r[3] = (m_halt != 0);
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on) begin
            check("R1 halt", 32'(core_halt), 32'(m_halt != 0));
            check("R4 clk_en", 32'(core_clk_en), 32'(exp_en()));
            check("R6 req", 32'(opp_req), 32'(m_st == 1 || m_st == 3));
            check("R6 low", 32'(opp_low), 32'(m_st == 1 || m_st == 2));
            check("R8 rdata", reg_rdata, exp_rd());
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr_reg(input logic a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick(1);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_reg(input logic a, output logic [31:0] d);
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
        tick(1);
    endtask

    task automatic count_en(output int n);
        n = 0;
        repeat (8) begin
            @(negedge clk);
            if (core_clk_en) n++;
        end
        tick(1);
    endtask

    // Acknowledge responder with a programmable delay
    initial begin
        int waited = 0;
        forever begin
            @(posedge clk);
            #1;
            if (opp_req) begin
                if (waited >= ack_delay) begin opp_ack = 1'b1; waited = 0; end
                else begin opp_ack = 1'b0; waited++; end
            end else begin
                opp_ack = 1'b0; waited = 0;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // ---------------- directed sequence ----------------
    initial begin
        logic [31:0] rd;
        int n;
        @(posedge clk); #1;
        cmp_on = 1;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R3: reset state
        @(negedge clk);
        check("R3 clk_en after reset", 32'(core_clk_en), 32'd1);
        check("R3 halt after reset", 32'(core_halt), 32'd0);
        check("R3 req after reset", 32'(opp_req), 32'd0);
        tick(1);
        rd_reg(1'b0, rd);
        check("R3 ctrl after reset", rd, 32'd0);

        // R10: episode with no method selected
        mon_trip = 1'b1; tick(20);
        @(negedge clk);
        check("R10 clk_en no method", 32'(core_clk_en), 32'd1);
        check("R10 no request", 32'(opp_req), 32'd0);
        tick(1);
        mon_trip = 1'b0; tick(24);
        rd_reg(1'b1, rd);
        check("R10 sticky untouched", 32'(rd[2]), 32'd0);

        // R4: gating with duty 3, then duty 0 (acts as 4)
        wr_reg(1'b0, 32'h0000_0308);
        mon_trip = 1'b1; tick(6);
        count_en(n);
        check("R4 duty 3", 32'(n), 32'd3);
        wr_reg(1'b0, 32'h0000_0008);
        tick(2);
        count_en(n);
        check("R4 duty 0 as 4", 32'(n), 32'd4);

        // R5: episode survives the quiet window, then ends
        mon_trip = 1'b0; tick(3);
        count_en(n);
        check("R5 still throttled in quiet window", 32'(n), 32'd4);
        tick(14);
        count_en(n);
        check("R5 episode over", 32'(n), 32'd8);

        // R9: sticky flag, write 0 ignored, write 1 clears
        rd_reg(1'b1, rd);
        check("R9 sticky set", 32'(rd[2]), 32'd1);
        wr_reg(1'b1, 32'h0);
        rd_reg(1'b1, rd);
        check("R9 write 0 keeps", 32'(rd[2]), 32'd1);
        wr_reg(1'b1, 32'h4);
        rd_reg(1'b1, rd);
        check("R9 write 1 clears", 32'(rd[2]), 32'd0);

        // R7/R6: both methods enabled, request wins
        ack_delay = 3;
        wr_reg(1'b0, 32'h0001_0208);
        rd_reg(1'b0, rd);
        check("R8 ctrl readback", rd, 32'h0001_0208);
        mon_trip = 1'b1; tick(6);
        count_en(n);
        check("R7 no gating when both set", 32'(n), 32'd8);
        @(negedge clk);
        check("R6 lowered point held", 32'(opp_low), 32'd1);
        tick(1);
        mon_trip = 1'b0; tick(40);
        @(negedge clk);
        check("R6 back to normal", 32'(opp_req | opp_low), 32'd0);
        tick(1);

        // Episode ends while the lowering request is unacknowledged
        ack_delay = 30;
        mon_trip = 1'b1; tick(3);
        mon_trip = 1'b0; tick(90);
        @(negedge clk);
        check("R6 release after late ack", 32'(opp_req | opp_low), 32'd0);
        tick(1);

        // R5: bursts with short gaps keep one episode running
        ack_delay = 1;
        wr_reg(1'b0, 32'h0000_0708);
        for (int i = 0; i < 4; i++) begin
            mon_trip = 1'b1; tick(2);
            mon_trip = 1'b0; tick(10);
        end
        count_en(n);
        check("R5 bursts hold episode", 32'(n), 32'd7);

        // R1/R2: catastrophic trip during gating
        mon_trip = 1'b1; tick(4);
        cat_trip = 1'b1; tick(2);
        cat_trip = 1'b0; tick(8);
        @(negedge clk);
        check("R1 halt set", 32'(core_halt), 32'd1);
        check("R2 clk_en low in halt", 32'(core_clk_en), 32'd0);
        tick(1);
        mon_trip = 1'b0; tick(50);
        rd_reg(1'b1, rd);
        check("R2 halt persists", 32'(rd[3]), 32'd1);
        rst_n = 1'b0; tick(2);
        rst_n = 1'b1; tick(1);
        @(negedge clk);
        check("R3 halt cleared by reset", 32'(core_halt), 32'd0);
        tick(4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule